// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block is the host side of an 8-bit multiplexed NAND flash bus. A user asks for one operation at a time: page read, page program, block erase, status read, ID read or device reset. The request carries the opcode, the row and column address, the page region to read and a byte count. The sequencer then puts the command, address and data bytes onto the shared I/O lines in the order the device expects. It raises the command-latch or address-latch line for each byte and strobes write-enable or read-enable with pulse widths set by parameters.

Once a read has been addressed, or a program, erase or reset has been confirmed, the sequencer waits a short fixed window and then polls the ready/busy line until the device is free. After a program or erase it reads the device status and keeps bit 0 as a pass/fail flag. Read bytes are streamed out one per strobe. Program bytes are pulled from the user one at a time through a take pulse. Every operation ends with a one-cycle done pulse.

Top module: `nfc_sequencer`

## Requirements
- R1: After reset, and while idle: chip enable, write strobe and read strobe are high (inactive), the latch lines are low, the I/O is not driven, and busy, done and status_fail are low.
- R2: A command byte is latched on the rising write strobe with the command line high and the address line low. An address byte is latched with the address line high and the command line low. A data byte is latched with both lines low. The two latch lines are never high together, and chip enable stays low whenever a strobe is low.
- R3: Every write or read strobe is low for exactly T_LOW clocks and high for at least T_HIGH clocks. The latch lines and output byte are set at least T_SETUP clocks before the strobe falls and are held until after it rises.
- R4: Page read (op 0) sends a region command (req_area 0 → 00h, 1 → 01h, 2 → 50h), then the column, row bits 7:0 and row bits 15:8. It then waits for ready and reads req_len bytes, each presented on rd_data with a one-cycle rd_valid.
- R5: Page program (op 1) sends 80h, the same three address bytes and req_len data bytes taken from wr_data (one wr_take pulse per byte, in order), then 10h.
- R6: Block erase (op 2) sends 60h, row bits 7:0, row bits 15:8 and then D0h. No column byte is sent.
- R7: After a program, erase or reset confirm, the sequencer waits at least T_WB clocks and then until R/B# is seen high. For program and erase it then sends 70h, reads one byte and sets status_fail to that byte's bit 0.
- R8: Status read (op 3) sends 70h and returns one byte on rd_data. ID read (op 4) sends 90h and returns req_len bytes. Reset (op 5) sends FFh and then waits for ready.
- R9: done is high for exactly one clock at the end of each operation. A read or program with req_len 0 has no data cycles. Op codes 6 and 7 finish with done and no bus cycles.
- R10: req_start is taken only while busy is low. A request during an operation, including the cycle in which done is high, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken when idle |
| req_op | input | 3 | Operation code |
| req_area | input | 2 | Read region select |
| req_col | input | 8 | Column address byte |
| req_row | input | ROW_W | Row (page) address |
| req_len | input | LEN_W | Data byte count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status_fail | output | 1 | Bit 0 of the last post-operation status |
| wr_data | input | 8 | Program byte offered by the user |
| wr_take | output | 1 | Current wr_data byte has been sent |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data holds a new byte |
| nf_io_out | output | 8 | Flash I/O driven value |
| nf_io_oe | output | 1 | Flash I/O output enable |
| nf_io_in | input | 8 | Flash I/O sampled value |
| nf_cle | output | 1 | Command latch line |
| nf_ale | output | 1 | Address latch line |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_rb_n | input | 1 | Ready (high) / busy (low) from the device |

## Verification
Two things can land in the same clock: a new user request and the completion pulse of the running operation. The bench drives req_start in the exact cycle that done is high, and once more partway through a read. It then checks that the flash bus log holds only the bytes of the first operation, that done fired once and that busy returns low. A second overlap is the end of the fixed wait window against the release of R/B#. The device model holds R/B# low long past T_WB, and the bench requires done to come later than the clock in which R/B# rose.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  // operation codes seen on req_op
  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_PROG   = 3'd1;
  localparam logic [2:0] OP_ERASE  = 3'd2;
  localparam logic [2:0] OP_STATUS = 3'd3;
  localparam logic [2:0] OP_ID     = 3'd4;
  localparam logic [2:0] OP_RESET  = 3'd5;

  // device command bytes
  localparam logic [7:0] CMD_RD_LO    = 8'h00;
  localparam logic [7:0] CMD_RD_HI    = 8'h01;
  localparam logic [7:0] CMD_RD_SPARE = 8'h50;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_ID       = 8'h90;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_WR, CYC_RD} cyc_kind_e;
endpackage

// File: rtl/nfc_bus_cycle.sv
// One flash bus cycle: setup, strobe low, strobe high, then ack.
module nfc_bus_cycle
  import nfc_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_LOW   = 2,
  parameter int T_HIGH  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  cyc_kind_e kind,
  input  logic [7:0] byte_in,
  input  logic [7:0] io_in,
  output logic      cle,
  output logic      ale,
  output logic      we_n,
  output logic      re_n,
  output logic [7:0] io_out,
  output logic      io_oe,
  output logic      ack,
  output logic [7:0] rd_byte
);
  localparam int TM1 = (T_SETUP > T_LOW) ? T_SETUP : T_LOW;
  localparam int TMX = (TM1 > T_HIGH) ? TM1 : T_HIGH;
  localparam int CW  = (TMX < 2) ? 1 : $clog2(TMX);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} ph_e;

  ph_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  cyc_kind_e  kind_q, kind_d;
  logic [7:0] byte_q, byte_d;
  logic [7:0] rd_q, rd_d;
  logic       cnt_last;

  always_comb begin
    case (ph_q)
      PH_SETUP: cnt_last = (cnt_q == CW'(T_SETUP - 1));
      PH_LOW:   cnt_last = (cnt_q == CW'(T_LOW - 1));
      PH_HIGH:  cnt_last = (cnt_q == CW'(T_HIGH - 1));
      default:  cnt_last = 1'b0;
    endcase
  end

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    byte_d = byte_q;
    rd_d   = rd_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        ph_d   = PH_SETUP;
        cnt_d  = '0;
        kind_d = kind;
        byte_d = byte_in;
      end
      PH_SETUP: if (cnt_last) begin
        ph_d  = PH_LOW;
        cnt_d = '0;
      end else cnt_d = cnt_q + 1'b1;
      PH_LOW: if (cnt_last) begin
        ph_d  = PH_HIGH;
        cnt_d = '0;
        if (kind_q == CYC_RD) rd_d = io_in;
      end else cnt_d = cnt_q + 1'b1;
      PH_HIGH: if (cnt_last) ph_d = PH_IDLE;
               else cnt_d = cnt_q + 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= CYC_CMD;
      byte_q <= '0;
      rd_q   <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      byte_q <= byte_d;
      rd_q   <= rd_d;
    end
  end

  logic active;
  assign active  = (ph_q != PH_IDLE);
  assign cle     = active && (kind_q == CYC_CMD);
  assign ale     = active && (kind_q == CYC_ADDR);
  assign we_n    = !((ph_q == PH_LOW) && (kind_q != CYC_RD));
  assign re_n    = !((ph_q == PH_LOW) && (kind_q == CYC_RD));
  assign io_oe   = active && (kind_q != CYC_RD);
  assign io_out  = byte_q;
  assign ack     = (ph_q == PH_HIGH) && cnt_last;
  assign rd_byte = rd_q;

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  p_hold_at_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(cle) && $stable(ale) && $stable(io_out)));
endmodule

// File: rtl/nfc_ready_wait.sv
// Fixed wait window, then poll the synchronised ready/busy line.
module nfc_ready_wait #(
  parameter int T_WB   = 4,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n,
  input  logic start,
  output logic ready
);
  localparam int WW = (T_WB < 2) ? 1 : $clog2(T_WB);

  typedef enum logic [1:0] {W_IDLE, W_HOLD, W_POLL} w_e;

  w_e              st_q, st_d;
  logic [WW-1:0]   cnt_q, cnt_d;
  logic [SYNC_N-1:0] sync_q;
  logic            rb_s;

  assign rb_s = sync_q[SYNC_N-1];

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      W_IDLE: if (start) begin
        st_d  = W_HOLD;
        cnt_d = '0;
      end
      W_HOLD: if (cnt_q == WW'(T_WB - 1)) st_d = W_POLL;
              else cnt_d = cnt_q + 1'b1;
      W_POLL: if (rb_s) st_d = W_IDLE;
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      cnt_q  <= '0;
      sync_q <= '1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sync_q <= {sync_q[SYNC_N-2:0], rb_n};
    end
  end

  assign ready = (st_q == W_POLL) && rb_s;

  p_ready_after_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(rb_n, 2));
endmodule

// File: rtl/nfc_sequencer.sv
module nfc_sequencer
  import nfc_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_LOW   = 2,
  parameter int T_HIGH  = 2,
  parameter int T_WB    = 4,
  parameter int ROW_W   = 16,   // multiple of 8
  parameter int LEN_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic [2:0]       req_op,
  input  logic [1:0]       req_area,
  input  logic [7:0]       req_col,
  input  logic [ROW_W-1:0] req_row,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             status_fail,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic [7:0]       nf_io_out,
  output logic             nf_io_oe,
  input  logic [7:0]       nf_io_in,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_ce_n,
  output logic             nf_we_n,
  output logic             nf_re_n,
  input  logic             nf_rb_n
);
  localparam int ROW_BYTES = ROW_W / 8;
  localparam int AIW       = $clog2(ROW_BYTES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WR, S_CMD2, S_WAIT, S_STCMD, S_STRD, S_RD, S_DONE
  } st_e;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  st_e              st_q, st_d;
  logic [2:0]       op_q, op_d;
  logic [1:0]       area_q, area_d;
  logic [7:0]       col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [AIW-1:0]   idx_q, idx_d;
  logic             launched_q, launched_d;
  logic             fail_q, fail_d;

  logic             cyc_start, cyc_ack, rdy_start, rdy_done;
  cyc_kind_e        cyc_kind;
  logic [7:0]       cyc_byte, cyc_rd, first_cmd, addr_byte;
  logic             in_cycle, len_zero, cnt_end;

  assign len_zero = (len_q == '0);
  assign cnt_end  = (cnt_q == len_q - 1'b1);

  always_comb begin
    case (op_q)
      OP_READ:   first_cmd = (area_q == 2'd0) ? CMD_RD_LO :
                             (area_q == 2'd1) ? CMD_RD_HI : CMD_RD_SPARE;
      OP_PROG:   first_cmd = CMD_PG_SETUP;
      OP_ERASE:  first_cmd = CMD_ER_SETUP;
      OP_STATUS: first_cmd = CMD_STATUS;
      OP_ID:     first_cmd = CMD_ID;
      default:   first_cmd = CMD_RESET;
    endcase
  end

  always_comb begin
    addr_byte = col_q;
    for (int k = 0; k < ROW_BYTES; k++)
      if (idx_q == AIW'(k + 1)) addr_byte = row_q[8*k +: 8];
  end

  // what the bus-cycle engine does in each step
  always_comb begin
    in_cycle = 1'b1;
    cyc_kind = CYC_CMD;
    cyc_byte = first_cmd;
    case (st_q)
      S_CMD1:  ;
      S_ADDR:  begin cyc_kind = CYC_ADDR; cyc_byte = addr_byte; end
      S_WR:    begin cyc_kind = CYC_WR;   cyc_byte = wr_data;   end
      S_CMD2:  cyc_byte = (op_q == OP_PROG) ? CMD_PG_GO : CMD_ER_GO;
      S_STCMD: cyc_byte = CMD_STATUS;
      S_STRD, S_RD: cyc_kind = CYC_RD;
      default: in_cycle = 1'b0;
    endcase
  end

  assign cyc_start = in_cycle && !launched_q;
  assign rdy_start = (st_q == S_WAIT) && !launched_q;

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    area_d = area_q;
    col_d  = col_q;
    row_d  = row_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    fail_d = fail_q;
    case (st_q)
      S_IDLE: if (req_start) begin
        op_d   = req_op;
        area_d = req_area;
        col_d  = req_col;
        row_d  = req_row;
        len_d  = req_len;
        fail_d = 1'b0;
        cnt_d  = '0;
        st_d   = (req_op > OP_RESET) ? S_DONE : S_CMD1;
      end
      S_CMD1: if (cyc_ack) begin
        case (op_q)
          OP_READ, OP_PROG: begin st_d = S_ADDR; idx_d = '0; end
          OP_ERASE:         begin st_d = S_ADDR; idx_d = AIW'(1); end
          OP_STATUS:        st_d = S_RD;
          OP_ID:            st_d = len_zero ? S_DONE : S_RD;
          default:          st_d = S_WAIT;
        endcase
      end
      S_ADDR: if (cyc_ack) begin
        if (idx_q == AIW'(ROW_BYTES)) begin
          case (op_q)
            OP_READ: st_d = S_WAIT;
            OP_PROG: st_d = len_zero ? S_CMD2 : S_WR;
            default: st_d = S_CMD2;
          endcase
        end else idx_d = idx_q + 1'b1;
      end
      S_WR: if (cyc_ack) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_end) st_d = S_CMD2;
      end
      S_CMD2: if (cyc_ack) st_d = S_WAIT;
      S_WAIT: if (rdy_done) begin
        case (op_q)
          OP_READ:           st_d = len_zero ? S_DONE : S_RD;
          OP_PROG, OP_ERASE: st_d = S_STCMD;
          default:           st_d = S_DONE;
        endcase
      end
      S_STCMD: if (cyc_ack) st_d = S_STRD;
      S_STRD: if (cyc_ack) begin
        fail_d = cyc_rd[0];
        st_d   = S_DONE;
      end
      S_RD: if (cyc_ack) begin
        cnt_d = cnt_q + 1'b1;
        if ((op_q == OP_STATUS) || cnt_end) st_d = S_DONE;
      end
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    launched_d = launched_q | cyc_start | rdy_start;
    if (st_d != st_q || cyc_ack || rdy_done) launched_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      st_q       <= S_IDLE;
      op_q       <= '0;
      area_q     <= '0;
      col_q      <= '0;
      row_q      <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      idx_q      <= '0;
      launched_q <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      op_q       <= op_d;
      area_q     <= area_d;
      col_q      <= col_d;
      row_q      <= row_d;
      len_q      <= len_d;
      cnt_q      <= cnt_d;
      idx_q      <= idx_d;
      launched_q <= launched_d;
      fail_q     <= fail_d;
    end
  end

  nfc_bus_cycle #(.T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH)) u_cycle (
    .clk     (clk),
    .rst_n   (rst_int),
    .start   (cyc_start),
    .kind    (cyc_kind),
    .byte_in (cyc_byte),
    .io_in   (nf_io_in),
    .cle     (nf_cle),
    .ale     (nf_ale),
    .we_n    (nf_we_n),
    .re_n    (nf_re_n),
    .io_out  (nf_io_out),
    .io_oe   (nf_io_oe),
    .ack     (cyc_ack),
    .rd_byte (cyc_rd)
  );

  nfc_ready_wait #(.T_WB(T_WB), .SYNC_N(2)) u_ready (
    .clk   (clk),
    .rst_n (rst_int),
    .rb_n  (nf_rb_n),
    .start (rdy_start),
    .ready (rdy_done)
  );

  assign busy        = (st_q != S_IDLE);
  assign done        = (st_q == S_DONE);
  assign nf_ce_n     = (st_q == S_IDLE) || (st_q == S_DONE);
  assign status_fail = fail_q;
  assign wr_take     = (st_q == S_WR) && cyc_ack;
  assign rd_valid    = (st_q == S_RD) && cyc_ack;
  assign rd_data     = cyc_rd;

  p_busy_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_int)
    (busy && req_start) |=> $stable(op_q));
  p_done_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_int)
    done |=> !done);
  p_ce_with_strobe_r2: assert property (@(posedge clk) disable iff (!rst_int)
    (!nf_we_n || !nf_re_n) |-> !nf_ce_n);
  p_take_only_prog_r5: assert property (@(posedge clk) disable iff (!rst_int)
    wr_take |-> (op_q == OP_PROG));
endmodule

// File: tb/sim_nfc_sequencer.sv
module sim_nfc_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TL   = 2;
  localparam int BUSY = 40;

  logic clk = 0;
  logic rst_n = 0;
  logic req_start = 0;
  logic [2:0] req_op = 0;
  logic [1:0] req_area = 0;
  logic [7:0] req_col = 0;
  logic [15:0] req_row = 0;
  logic [9:0] req_len = 0;
  logic busy, done, status_fail, wr_take, rd_valid;
  logic [7:0] wr_data, rd_data, nf_io_out;
  logic [7:0] nf_io_in = 0;
  logic nf_io_oe, nf_cle, nf_ale, nf_ce_n, nf_we_n, nf_re_n;
  logic nf_rb_n = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nfc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
    .req_area(req_area), .req_col(req_col), .req_row(req_row), .req_len(req_len),
    .busy(busy), .done(done), .status_fail(status_fail),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_rb_n(nf_rb_n)
  );

  int n_checks = 0, n_errors = 0, cyc = 0;
  int ev_n = 0, rd_n = 0, re_pulses = 0, done_cnt = 0, done_cyc = 0, rel_cyc = 0;
  int width_err = 0, bus_err = 0, busy_cnt = 0, wr_idx = 0, addr_cnt = 0, rd_idx = 0;
  int we_low = 0, re_low = 0;
  logic [1:0] ev_t [0:63];
  logic [7:0] ev_b [0:63];
  logic [7:0] rd_buf [0:63];
  logic [7:0] last_cmd = 8'hEE, status_val = 8'h00;
  logic prev_we = 1, prev_re = 1, prev_lat = 0;

  function automatic logic [7:0] wpat(int k);
    return 8'(k * 3 + 8'h11);
  endfunction
  assign wr_data = wpat(wr_idx);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // device model and bus monitor, all at the falling clock edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
    if (nf_cle && nf_ale) bus_err++;
    if ((!nf_we_n || !nf_re_n) && nf_ce_n) bus_err++;
    if (!nf_we_n) we_low++;
    if (!nf_re_n) re_low++;
    if (prev_we && !nf_we_n && (nf_cle || nf_ale) && !prev_lat) bus_err++;
    if (!prev_we && nf_we_n) begin
      if (we_low != TL) width_err++;
      we_low = 0;
      if (ev_n < 64) begin
        ev_t[ev_n] = nf_cle ? 2'd1 : nf_ale ? 2'd2 : 2'd3;
        ev_b[ev_n] = nf_io_out;
      end
      ev_n++;
      if (nf_cle) begin
        last_cmd = nf_io_out; addr_cnt = 0; rd_idx = 0;
        if (nf_io_out == 8'h10 || nf_io_out == 8'hD0 || nf_io_out == 8'hFF)
          busy_cnt = BUSY;
      end else if (nf_ale) begin
        addr_cnt++;
        if ((last_cmd == 8'h00 || last_cmd == 8'h01 || last_cmd == 8'h50) && addr_cnt == 3)
          busy_cnt = BUSY;
      end
    end
    if (prev_re && !nf_re_n) begin
      re_pulses++;
      nf_io_in <= (last_cmd == 8'h70) ? status_val :
                  (last_cmd == 8'h90) ? 8'(8'h30 + rd_idx) : 8'(8'hA0 + rd_idx);
    end
    if (!prev_re && nf_re_n) begin
      if (re_low != TL) width_err++;
      re_low = 0;
      rd_idx++;
    end
    if (busy_cnt > 0) begin
      busy_cnt--;
      nf_rb_n <= 0;
      if (busy_cnt == 0) begin nf_rb_n <= 1; rel_cyc = cyc; end
    end
    if (rd_valid) begin
      if (rd_n < 64) rd_buf[rd_n] = rd_data;
      rd_n++;
    end
    if (wr_take) wr_idx++;
    if (done) begin done_cnt++; done_cyc = cyc; end
    prev_we = nf_we_n; prev_re = nf_re_n; prev_lat = nf_cle || nf_ale;
  end

  task automatic run_op(input logic [2:0] op, input logic [1:0] area,
                        input logic [15:0] row, input logic [7:0] col, input int len);
    int d0;
    @(negedge clk);
    ev_n = 0; rd_n = 0; wr_idx = 0; rel_cyc = 0; re_pulses = 0;
    d0 = done_cnt;
    req_op = op; req_area = area; req_row = row; req_col = col; req_len = 10'(len);
    req_start = 1;
    @(negedge clk);
    req_start = 0;
    while (done_cnt == d0) @(negedge clk);
  endtask

  task automatic chk_ev(input int i, input logic [1:0] t, input logic [7:0] b, input string req);
    check(ev_t[i] == t && ev_b[i] == b, req, {22'd0, ev_t[i], ev_b[i]}, {22'd0, t, b});
  endtask

  task automatic t_reset;
    check(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_io_oe,
          "R1 bus idle", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe}, 6'b111000);
    check(!busy && !done && !status_fail, "R1 status idle", {busy, done, status_fail}, 0);
  endtask

  task automatic t_read(input logic [1:0] area, input logic [7:0] cmd);
    run_op(3'd0, area, 16'hB2C1, 8'h37, 4);
    check(ev_n == 4, "R4 read cycle count", ev_n, 4);
    chk_ev(0, 2'd1, cmd, "R4 region command");
    chk_ev(1, 2'd2, 8'h37, "R4 column");
    chk_ev(2, 2'd2, 8'hC1, "R4 row low");
    chk_ev(3, 2'd2, 8'hB2, "R4 row high");
    check(rd_n == 4, "R4 read byte count", rd_n, 4);
    for (int k = 0; k < 4; k++)
      check(rd_buf[k] == 8'(8'hA0 + k), "R4 read data", rd_buf[k], 8'hA0 + k);
    check(done_cyc > rel_cyc && rel_cyc != 0, "R7 read waits for ready", done_cyc, rel_cyc);
  endtask

  task automatic t_prog(input int len, input logic [7:0] st);
    status_val = st;
    run_op(3'd1, 2'd0, 16'h0420, 8'h05, len);
    check(ev_n == 6 + len, "R5 program cycle count", ev_n, 6 + len);
    chk_ev(0, 2'd1, 8'h80, "R5 setup command");
    chk_ev(1, 2'd2, 8'h05, "R5 column");
    chk_ev(2, 2'd2, 8'h20, "R5 row low");
    chk_ev(3, 2'd2, 8'h04, "R5 row high");
    for (int k = 0; k < len; k++) chk_ev(4 + k, 2'd3, wpat(k), "R5 data byte");
    check(wr_idx == len, "R5 take pulses", wr_idx, len);
    chk_ev(4 + len, 2'd1, 8'h10, "R5 confirm");
    chk_ev(5 + len, 2'd1, 8'h70, "R7 status command");
    check(status_fail == st[0], "R7 status flag", status_fail, st[0]);
    check(rel_cyc != 0 && done_cyc > rel_cyc, "R7 program waits", done_cyc, rel_cyc);
    if (len == 0) check(re_pulses == 1, "R9 no data cycles", re_pulses, 1);
  endtask

  task automatic t_erase(input logic [7:0] st);
    status_val = st;
    run_op(3'd2, 2'd0, 16'h7F3E, 8'h99, 0);
    check(ev_n == 5, "R6 erase cycle count", ev_n, 5);
    chk_ev(0, 2'd1, 8'h60, "R6 setup command");
    chk_ev(1, 2'd2, 8'h3E, "R6 row low");
    chk_ev(2, 2'd2, 8'h7F, "R6 row high");
    chk_ev(3, 2'd1, 8'hD0, "R6 confirm");
    chk_ev(4, 2'd1, 8'h70, "R7 status command");
    check(status_fail == st[0], "R7 erase status flag", status_fail, st[0]);
  endtask

  task automatic t_misc;
    status_val = 8'hC1;
    run_op(3'd3, 2'd0, 16'h0, 8'h0, 0);
    check(ev_n == 1, "R8 status one cycle", ev_n, 1);
    chk_ev(0, 2'd1, 8'h70, "R8 status command");
    check(rd_n == 1 && rd_buf[0] == 8'hC1, "R8 status byte", rd_buf[0], 8'hC1);
    run_op(3'd4, 2'd0, 16'h0, 8'h0, 3);
    chk_ev(0, 2'd1, 8'h90, "R8 id command");
    check(rd_n == 3 && rd_buf[2] == 8'h32, "R8 id bytes", rd_buf[2], 8'h32);
    run_op(3'd5, 2'd0, 16'h0, 8'h0, 0);
    chk_ev(0, 2'd1, 8'hFF, "R8 reset command");
    check(rel_cyc != 0 && done_cyc > rel_cyc, "R8 reset waits", done_cyc, rel_cyc);
    run_op(3'd0, 2'd0, 16'h0001, 8'h00, 0);
    check(re_pulses == 0 && rd_n == 0, "R9 zero read", re_pulses, 0);
    run_op(3'd6, 2'd0, 16'h0, 8'h0, 2);
    check(ev_n == 0 && re_pulses == 0, "R9 undefined op", ev_n, 0);
  endtask

  task automatic t_overlap;
    int d0;
    @(negedge clk);
    ev_n = 0; rd_n = 0;
    d0 = done_cnt;
    req_op = 3'd0; req_area = 2'd0; req_row = 16'h1234; req_col = 8'h10; req_len = 10'd2;
    req_start = 1;
    @(negedge clk);
    req_start = 0;
    repeat (3) @(negedge clk);
    req_op = 3'd5; req_start = 1;
    @(negedge clk);
    req_start = 0;
    while (!done) @(negedge clk);
    req_op = 3'd2; req_start = 1;
    @(negedge clk);
    req_start = 0;
    repeat (20) @(negedge clk);
    check(ev_n == 4, "R10 no extra bus cycles", ev_n, 4);
    check(done_cnt == d0 + 1, "R10 single done", done_cnt, d0 + 1);
    check(!busy, "R10 idle after", busy, 0);
    check(rd_n == 2, "R10 read intact", rd_n, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_read(2'd0, 8'h00);
    t_read(2'd1, 8'h01);
    t_read(2'd2, 8'h50);
    t_prog(5, 8'hC0);
    t_prog(0, 8'hC1);
    t_erase(8'hE1);
    t_erase(8'hE0);
    t_misc;
    t_overlap;
    check(width_err == 0, "R3 strobe width", width_err, 0);
    check(bus_err == 0, "R2 latch lines", bus_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule